// File: doc/BRIEF.md
# Sequential One-Bit Tally

This block counts how many bits are set in a data word. It does not use a parallel adder tree. It uses a small datapath with a shift register, a count register and a single captured-bit flop, and a four-state controller steps that datapath one operation per clock.

A client drives a word on `data_i` and holds `start_i` high for one clock while `done_o` is high. The block then runs by itself. It shifts the word out of the top of the shift register one bit per pass, and it increments the count after every 1 bit it captures. The run ends as soon as the shift register holds only zeros. `done_o` then rises and `count_o` holds the result until the next start.

The count register is preset to all ones when a word is loaded, so the first increment of the run brings it to zero. Each next-state bit of the controller comes from its own 4:1 multiplexer, selected by the present state. The data inputs of each multiplexer are constants or the start, zero and captured-bit conditions.

Top module: `ones_tally`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block goes to idle. After that edge `done_o` is 1 and `count_o` is 0.
- R2: If `start_i` is 1 at a rising edge while `done_o` is 1, the word on `data_i` is loaded and `done_o` is 0 after that edge.
- R3: If `start_i` is 0 while `done_o` is 1, the block stays idle: `done_o` stays 1 and `count_o` does not change, whatever `data_i` carries.
- R4: When `done_o` rises at the end of a run, `count_o` equals the number of 1 bits in the loaded word. This gives 0 for 8'h00 and 8 for 8'hFF.
- R5: While a run is in progress (`done_o` is 0), `start_i` and `data_i` have no effect. The result is that of the word loaded at the start.
- R6: While the block stays idle, `count_o` holds the last result unchanged.
- R7: Each shift step moves the held word left by one bit. The bit leaving the top goes into the captured-bit flop, and a 0 enters at the bottom. Only a captured 1 leads to an increment.
- R8: A run keeps `done_o` low for exactly 1 + 2*s + p clocks. Here p is the number of 1 bits in the word. s is 0 for a zero word; otherwise s is DATA_W minus the index of the lowest set bit. Examples: 8'h00 gives 1 clock, 8'h80 gives 4, 8'h01 gives 18 and 8'hFF gives 25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled only while idle |
| data_i | input | DATA_W | Word to be tallied, sampled with the start |
| count_o | output | CNT_W | Number of set bits; CNT_W = clog2(DATA_W+1) |
| done_o | output | 1 | High while the controller is idle |

## Verification
A wrong controller state or a wrong multiplexer data input changes how long `done_o` stays low. Measuring that time against 1 + 2*s + p exposes the fault within the same run, often within one or two clocks. A fault in the shift path or in the captured-bit flop either drops or adds an increment, and that shows in `count_o` on the clock where `done_o` rises. A reload during a run, or drift while idle, shows as a `count_o` change on the very next clock.

// File: rtl/ones_tally_pkg.sv
package ones_tally_pkg;

  // Controller state encoding, two flops {g1,g0}
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_INC   = 2'b01,
    ST_SHIFT = 2'b10,
    ST_TEST  = 2'b11
  } tally_state_e;

  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned STATE_W    = 2;

endpackage

// File: rtl/ones_tally_mux4.sv
module ones_tally_mux4 (
  input  logic [3:0] in_i,
  input  logic [1:0] sel_i,
  output logic       out_o
);

  always_comb begin
    case (sel_i)
      2'd0:    out_o = in_i[0];
      2'd1:    out_o = in_i[1];
      2'd2:    out_o = in_i[2];
      default: out_o = in_i[3];
    endcase
  end

endmodule

// File: rtl/ones_tally_ctrl.sv
module ones_tally_ctrl
  import ones_tally_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic zero_i,
  input  logic ebit_i,
  output logic load_en_o,
  output logic inc_en_o,
  output logic shift_en_o,
  output logic done_o
);

  logic [STATE_W-1:0] g_q;
  logic [STATE_W-1:0] g_d;
  logic               done_q;

  // Data inputs per next-state bit, indexed by present state
  logic [STATE_W-1:0][NUM_STATES-1:0] mux_data;

  always_comb begin
    // bit 1 of the next state
    mux_data[1][ST_IDLE]  = 1'b0;
    mux_data[1][ST_INC]   = ~zero_i;
    mux_data[1][ST_SHIFT] = 1'b1;
    mux_data[1][ST_TEST]  = ~ebit_i;
    // bit 0 of the next state
    mux_data[0][ST_IDLE]  = start_i;
    mux_data[0][ST_INC]   = 1'b0;
    mux_data[0][ST_SHIFT] = 1'b1;
    mux_data[0][ST_TEST]  = ebit_i;
  end

  for (genvar b = 0; b < STATE_W; b++) begin : g_nxt
    ones_tally_mux4 u_mux (
      .in_i  (mux_data[b]),
      .sel_i (g_q),
      .out_o (g_d[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_q    <= ST_IDLE;
      done_q <= 1'b1;
    end else begin
      g_q    <= g_d;
      done_q <= (g_d == ST_IDLE);
    end
  end

  assign load_en_o  = (g_q == ST_IDLE) & start_i;
  assign inc_en_o   = (g_q == ST_INC);
  assign shift_en_o = (g_q == ST_SHIFT);
  assign done_o     = done_q;

endmodule

// File: rtl/ones_tally_shreg.sv
module ones_tally_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en_i,
  input  logic              shift_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              zero_o,
  output logic              ebit_o,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] word_q;
  logic              ebit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      ebit_q <= 1'b0;
    end else if (load_en_i) begin
      word_q <= data_i;
    end else if (shift_en_i) begin
      word_q <= {word_q[DATA_W-2:0], 1'b0};
      ebit_q <= word_q[DATA_W-1];
    end
  end

  assign zero_o = (word_q == '0);
  assign ebit_o = ebit_q;
  assign word_o = word_q;

endmodule

// File: rtl/ones_tally_count.sv
module ones_tally_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preset_en_i,
  input  logic             inc_en_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (preset_en_i) begin
      cnt_q <= '1;
    end else if (inc_en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/ones_tally.sv
module ones_tally #(
  parameter  int DATA_W = 8,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              done_o
);

  logic              load_en_w;
  logic              inc_en_w;
  logic              shift_en_w;
  logic              zero_w;
  logic              ebit_w;
  logic [DATA_W-1:0] word_w;

  ones_tally_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .zero_i     (zero_w),
    .ebit_i     (ebit_w),
    .load_en_o  (load_en_w),
    .inc_en_o   (inc_en_w),
    .shift_en_o (shift_en_w),
    .done_o     (done_o)
  );

  ones_tally_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk        (clk),
    .rst        (rst),
    .load_en_i  (load_en_w),
    .shift_en_i (shift_en_w),
    .data_i     (data_i),
    .zero_o     (zero_w),
    .ebit_o     (ebit_w),
    .word_o     (word_w)
  );

  ones_tally_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst         (rst),
    .preset_en_i (load_en_w),
    .inc_en_i    (inc_en_w),
    .count_o     (count_o)
  );

endmodule

// File: rtl/ones_tally_chk.sv
module ones_tally_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [DATA_W-1:0] data_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              done_o,
  input logic              shift_en,
  input logic              ebit,
  input logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst)                    cap_q <= '0;
    else if (done_o && start_i) cap_q <= data_i;
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (done_o && count_o == '0));

  // R2
  a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> !done_o);

  // R3
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(count_o)));

  // R4
  a_r4_final_count: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (count_o == CNT_W'($countones(cap_q))));

  // R5: while busy the count only holds or steps by one, never reloads
  a_r5_busy_no_reload: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  // R6
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(done_o) && !$past(start_i)) |-> $stable(count_o));

  // R7
  a_r7_shift_step: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (word == {$past(word[DATA_W-2:0]), 1'b0} && ebit == $past(word[DATA_W-1])));

endmodule

bind ones_tally ones_tally_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .data_i   (data_i),
  .count_o  (count_o),
  .done_o   (done_o),
  .shift_en (shift_en_w),
  .ebit     (ebit_w),
  .word     (word_w)
);

// File: tb/ones_tally_test.sv
module ones_tally_test;

  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int WDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [CNT_W-1:0]  count_o;
  logic              done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  ones_tally #(.DATA_W(DATA_W)) uut (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .data_i  (data_i),
    .count_o (count_o),
    .done_o  (done_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int ref_pop(input logic [DATA_W-1:0] w);
    int p = 0;
    for (int i = 0; i < DATA_W; i++) if (w[i]) p++;
    return p;
  endfunction

  function automatic int ref_busy(input logic [DATA_W-1:0] w);
    int s = 0;
    for (int i = DATA_W - 1; i >= 0; i--) if (w[i]) s = DATA_W - i;
    return 1 + 2 * s + ref_pop(w);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done_o), 1);
    check("R1 count after reset", int'(count_o), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One full run: checks start response, busy time and result
  task automatic t_run(input logic [DATA_W-1:0] w);
    int edges;
    @(negedge clk);
    data_i  = w;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    data_i  = ~w;
    edges   = 1;
    check("R2 done low after start", int'(done_o), 0);
    while (!done_o && edges < 200) begin
      @(negedge clk);
      edges++;
    end
    check("R8 busy length", edges - 1, ref_busy(w));
    check("R4 R7 final count", int'(count_o), ref_pop(w));
  endtask

  task automatic t_idle_hold();
    logic [CNT_W-1:0] held;
    int bad = 0;
    held = count_o;
    for (int i = 0; i < 10; i++) begin
      data_i = DATA_W'(i * 37 + 5);
      @(negedge clk);
      if (!done_o || count_o != held) bad++;
    end
    check("R3 R6 idle hold, bad cycles", bad, 0);
    check("R6 count after idle", int'(count_o), int'(held));
  endtask

  task automatic t_busy_start();
    int edges;
    @(negedge clk);
    data_i  = 8'h0F;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    edges   = 1;
    repeat (3) begin
      @(negedge clk);
      edges++;
    end
    data_i  = 8'hFF;
    start_i = 1'b1;
    @(negedge clk);
    edges++;
    start_i = 1'b0;
    data_i  = 8'h00;
    while (!done_o && edges < 200) begin
      @(negedge clk);
      edges++;
    end
    check("R5 count ignores busy start", int'(count_o), 4);
    check("R5 busy length ignores busy start", edges - 1, ref_busy(8'h0F));
  endtask

  initial begin
    t_reset();
    t_run(8'h00);
    t_run(8'hFF);
    t_run(8'h80);
    t_run(8'h01);
    t_idle_hold();
    t_run(8'h5A);
    t_busy_start();
    t_idle_hold();
    for (int k = 0; k < 8; k++) t_run(DATA_W'($urandom));
    t_reset();
    t_run(8'hA5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule